// File: doc/BRIEF.md
# Hinted Direct-Mapped Data Cache Controller

This block sits between a processor's load/store unit and a line-oriented memory port. It holds a direct-mapped array of tags, valid bits, dirty bits and line data. Each processor access carries two extra fields. The first is a 3-bit hint that software chooses for each access. The second is a 2-bit page policy that comes from the translation stage. Together they decide how the access is handled: hit or refill, a forced refill, a store kept in the cache, a write that goes through to memory while keeping the line, or a write that goes through and then drops the line.

Only one request is in flight at any time. The processor side accepts a request when `req_ready` is high. It then keeps `req_ready` low until the whole sequence the hint calls for has finished, and signals the end with a single-cycle `resp_valid`. The memory side issues one command at a time. A command is a line read, a line write, a word read or a word write. Each command is held until memory accepts it. Read data comes back later as a full line.

Address layout with default parameters: bits [1:0] are the byte offset, [3:2] select the word, [7:4] select the line and [31:8] are the tag.

Top module: `hinted_dcache`

## Requirements
- R1: Hint 0 (plain load): a hit returns the cached word with no memory command; a miss issues one line read (op 0), installs the line and returns the addressed word.
- R2: Hint 1 (refresh load) always refills the line from memory with a line read, even on a tag match, and returns the word from the fresh line. A dirty copy is first written back with a line write (op 1).
- R3: Hint 5 (cache-only store): on a hit it updates the cached word, marks the line dirty and issues no memory command. On a miss it issues one word write (op 3) and allocates nothing.
- R4: Hint 6 (write-through-keep): always issues one word write, and on a hit also updates the cached word.
- R5: Hint 7 (write-through-drop): on a miss or a clean hit it issues one word write. On a dirty hit it issues one line write carrying the line with the new word merged in. Any matching line is invalidated afterwards.
- R6: Hint 4 (plain store) under copy-back policy (code 0): a hit updates the word, marks the line dirty and issues no memory command. A miss issues one word write without allocating. A dirty line is written back with a line write before a refill replaces it.
- R7: Under write-through policy (code 1), a plain store behaves as write-through-keep and never marks the line dirty.
- R8: Under uncached policy (code 2), loads use one word read (op 2) and stores use one word write. The arrays are neither read for a hit nor changed.
- R9: Policy code 3 is treated as copy-back.
- R10: Hint codes 2 and 3 behave as plain loads.
- R11: After a request is accepted, `req_ready` stays low until the response. `resp_valid` lasts exactly one cycle. Memory commands appear only while a request is in flight.
- R12: A memory command keeps its op and address stable until `mem_cmd_ready`. Line commands carry a line-aligned address. Word commands deliver the word in every lane of `mem_cmd_wline`.
- R13: Reset clears all valid and dirty bits, raises `req_ready`, and lowers `resp_valid` and `mem_cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_hint | input | 3 | Access hint code |
| req_policy | input | 2 | Page policy code |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Load result (zero for stores) |
| mem_cmd_valid | output | 1 | Memory command present |
| mem_cmd_ready | input | 1 | Memory accepts command |
| mem_cmd_op | output | 2 | 0 read line, 1 write line, 2 read word, 3 write word |
| mem_cmd_addr | output | ADDR_W | Command byte address |
| mem_cmd_wline | output | WORDS*DATA_W | Write line or replicated word |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_line | input | WORDS*DATA_W | Returned line, word 0 in low bits |

## Verification
The two functions that can coincide are a victim writeback and the hint action that triggered it. A refresh load on a dirty line must write back and then refill the same line. A write-through-drop on a dirty line must fold the store into the writeback and also invalidate the line. The bench provokes both cases by first dirtying a line with a cache-only or plain store and then issuing the conflicting hint. It judges the result from the number of memory commands the access used and from later loads, which reveal what memory and the cache now hold. Memory acceptance is throttled in a fixed pattern, so command holding is exercised throughout.

// File: rtl/hdc_pkg.sv
// Shared codes and types for the hinted data cache.
// Assumes: hint is 3 bits, page policy 2 bits, memory op 2 bits.
package hdc_pkg;

    localparam logic [2:0] HINT_LOAD    = 3'd0;
    localparam logic [2:0] HINT_REFRESH = 3'd1;
    localparam logic [2:0] HINT_STORE   = 3'd4;
    localparam logic [2:0] HINT_CONLY   = 3'd5;
    localparam logic [2:0] HINT_WTKEEP  = 3'd6;
    localparam logic [2:0] HINT_WTDROP  = 3'd7;

    localparam logic [1:0] POL_CB = 2'd0;
    localparam logic [1:0] POL_WT = 2'd1;
    localparam logic [1:0] POL_UC = 2'd2;

    localparam logic [1:0] MOP_RD_LINE = 2'd0;
    localparam logic [1:0] MOP_WR_LINE = 2'd1;
    localparam logic [1:0] MOP_RD_WORD = 2'd2;
    localparam logic [1:0] MOP_WR_WORD = 2'd3;

    // Decoded treatment of one access
    typedef struct packed {
        logic is_load;    // access returns data
        logic bypass;     // uncached page: skip arrays
        logic refill;     // load must refill even on a tag match
        logic upd_hit;    // store writes the cached word on a hit
        logic dirty_hit;  // that write marks the line dirty
        logic wr_always;  // store always reaches memory
        logic drop_hit;   // matching line is invalidated
    } act_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_WB, S_FILL, S_FWAIT, S_WORD, S_UWAIT, S_RESP
    } ctl_st_e;

endpackage

// File: rtl/hdc_decode.sv
// Turns the hint and page policy into a set of action flags.
// Assumes: unknown hint codes fall back to plain load or plain store,
// and policy code 3 behaves as copy-back.
module hdc_decode
    import hdc_pkg::*;
(
    input  logic [2:0] hint,
    input  logic [1:0] policy,
    output act_t       act
);

    // Map hint and policy to flags
    always_comb begin
        act           = '0;
        act.is_load   = ~hint[2];
        act.bypass    = (policy == POL_UC);
        act.refill    = (hint == HINT_REFRESH);
        if (hint[2]) begin
            case (hint)
                HINT_WTKEEP: begin
                    act.upd_hit   = 1'b1;
                    act.wr_always = 1'b1;
                end
                HINT_WTDROP: begin
                    act.drop_hit  = 1'b1;
                    act.wr_always = 1'b1;
                end
                HINT_CONLY: begin
                    act.upd_hit   = 1'b1;
                    act.dirty_hit = 1'b1;
                end
                default: begin
                    act.upd_hit = 1'b1;
                    if (policy == POL_WT) act.wr_always = 1'b1;
                    else                  act.dirty_hit = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/hdc_store.sv
// Tag, valid, dirty and data storage for a direct-mapped cache.
// One shared index; line fill, word write and invalidate are mutually
// exclusive per cycle (fill wins, then invalidate, then word write).
// Assumes LINES and WORDS are powers of two.
module hdc_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(LINES)-1:0]      idx,
    output logic                          rd_valid,
    output logic                          rd_dirty,
    output logic [TAG_W-1:0]              rd_tag,
    output logic [WORDS*DATA_W-1:0]       rd_line,
    input  logic                          fill_we,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [WORDS*DATA_W-1:0]       fill_line,
    input  logic                          word_we,
    input  logic [$clog2(WORDS)-1:0]      word_sel,
    input  logic [DATA_W-1:0]             word_data,
    input  logic                          word_dirty,
    input  logic                          inval_we
);

    localparam int IDX_W  = $clog2(LINES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int LINE_W = WORDS * DATA_W;

    logic [LINES-1:0]  valid_vec;
    logic [LINES-1:0]  dirty_vec;
    logic [TAG_W-1:0]  tag_arr  [LINES];
    logic [LINE_W-1:0] data_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              v_q;
        logic              d_q;
        logic [TAG_W-1:0]  t_q;
        logic [LINE_W-1:0] l_q;
        logic              sel;

        assign sel = (idx == IDX_W'(g));

        // State bits of this line, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else if (sel) begin
                if (fill_we) begin
                    v_q <= 1'b1;
                    d_q <= 1'b0;
                end else if (inval_we) begin
                    v_q <= 1'b0;
                    d_q <= 1'b0;
                end else if (word_we && word_dirty) begin
                    d_q <= 1'b1;
                end
            end
        end

        // Tag and data of this line
        always_ff @(posedge clk) begin
            if (sel && fill_we) begin
                t_q <= fill_tag;
                l_q <= fill_line;
            end else if (sel && word_we) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (word_sel == WSEL_W'(w)) l_q[w*DATA_W +: DATA_W] <= word_data;
                end
            end
        end

        assign valid_vec[g] = v_q;
        assign dirty_vec[g] = d_q;
        assign tag_arr[g]   = t_q;
        assign data_arr[g]  = l_q;
    end

    assign rd_valid = valid_vec[idx];
    assign rd_dirty = dirty_vec[idx];
    assign rd_tag   = tag_arr[idx];
    assign rd_line  = data_arr[idx];

endmodule

// File: rtl/hdc_ctrl.sv
// Sequencer for one access at a time: lookup, writeback, refill,
// word transfer and response. Memory commands are held until accepted.
// Assumes memory returns exactly one mem_rd_valid per read command.
module hdc_ctrl
    import hdc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [ADDR_W-1:0]                     req_addr,
    input  logic [DATA_W-1:0]                     req_wdata,
    input  act_t                                  act_in,
    output logic                                  resp_valid,
    output logic [DATA_W-1:0]                     resp_rdata,
    output logic                                  mem_cmd_valid,
    input  logic                                  mem_cmd_ready,
    output logic [1:0]                            mem_cmd_op,
    output logic [ADDR_W-1:0]                     mem_cmd_addr,
    output logic [WORDS*DATA_W-1:0]               mem_cmd_wline,
    input  logic                                  mem_rd_valid,
    input  logic [WORDS*DATA_W-1:0]               mem_rd_line,
    output logic [$clog2(LINES)-1:0]              st_idx,
    input  logic                                  st_valid,
    input  logic                                  st_dirty,
    input  logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-$clog2(DATA_W/8)-1:0] st_tag,
    input  logic [WORDS*DATA_W-1:0]               st_line,
    output logic                                  fill_we,
    output logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-$clog2(DATA_W/8)-1:0] fill_tag,
    output logic [WORDS*DATA_W-1:0]               fill_line,
    output logic                                  word_we,
    output logic [$clog2(WORDS)-1:0]              word_sel,
    output logic [DATA_W-1:0]                     word_data,
    output logic                                  word_dirty,
    output logic                                  inval_we
);

    localparam int OFF_W  = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W;
    localparam int LINE_W = WORDS * DATA_W;
    localparam int LOW_W  = WSEL_W + OFF_W;

    ctl_st_e                 state, nxt;
    logic [ADDR_W-OFF_W-1:0] addr_q;
    logic [DATA_W-1:0]       wdata_q;
    act_t                    act_q;
    logic [DATA_W-1:0]       rdata_q;

    logic [TAG_W-1:0]  tag_c;
    logic [WSEL_W-1:0] wsel_c;
    logic              hit;
    logic [LINE_W-1:0] merged;
    logic [DATA_W-1:0] st_word;
    logic [DATA_W-1:0] mem_word;

    assign tag_c  = addr_q[ADDR_W-OFF_W-1 -: TAG_W];
    assign st_idx = addr_q[WSEL_W +: IDX_W];
    assign wsel_c = addr_q[WSEL_W-1:0];
    assign hit    = st_valid && (st_tag == tag_c);

    // Word selection and store-merge of the indexed line
    always_comb begin
        merged   = st_line;
        st_word  = '0;
        mem_word = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (wsel_c == WSEL_W'(w)) begin
                merged[w*DATA_W +: DATA_W] = wdata_q;
                st_word  = st_line[w*DATA_W +: DATA_W];
                mem_word = mem_rd_line[w*DATA_W +: DATA_W];
            end
        end
    end

    // Next state, memory command and array write controls
    always_comb begin
        nxt           = state;
        mem_cmd_valid = 1'b0;
        mem_cmd_op    = MOP_RD_LINE;
        mem_cmd_addr  = {addr_q[ADDR_W-OFF_W-1:WSEL_W], {LOW_W{1'b0}}};
        mem_cmd_wline = st_line;
        fill_we       = 1'b0;
        word_we       = 1'b0;
        word_dirty    = 1'b0;
        inval_we      = 1'b0;
        case (state)
            S_IDLE: if (req_valid) nxt = S_LOOK;
            S_LOOK: begin
                if (act_q.bypass) begin
                    nxt = S_WORD;
                end else if (act_q.is_load) begin
                    if (hit && !act_q.refill)       nxt = S_RESP;
                    else if (st_valid && st_dirty)  nxt = S_WB;
                    else                            nxt = S_FILL;
                end else if (act_q.drop_hit && hit && st_dirty) begin
                    nxt = S_WB;
                end else begin
                    word_we    = hit && act_q.upd_hit;
                    word_dirty = act_q.dirty_hit;
                    inval_we   = hit && act_q.drop_hit;
                    nxt        = (act_q.wr_always || !hit) ? S_WORD : S_RESP;
                end
            end
            S_WB: begin
                mem_cmd_valid = 1'b1;
                mem_cmd_op    = MOP_WR_LINE;
                mem_cmd_addr  = {st_tag, st_idx, {LOW_W{1'b0}}};
                mem_cmd_wline = act_q.is_load ? st_line : merged;
                if (mem_cmd_ready) begin
                    if (act_q.is_load) begin
                        nxt = S_FILL;
                    end else begin
                        inval_we = 1'b1;
                        nxt      = S_RESP;
                    end
                end
            end
            S_FILL: begin
                mem_cmd_valid = 1'b1;
                mem_cmd_op    = MOP_RD_LINE;
                if (mem_cmd_ready) nxt = S_FWAIT;
            end
            S_FWAIT: begin
                if (mem_rd_valid) begin
                    fill_we = 1'b1;
                    nxt     = S_RESP;
                end
            end
            S_WORD: begin
                mem_cmd_valid = 1'b1;
                mem_cmd_op    = act_q.is_load ? MOP_RD_WORD : MOP_WR_WORD;
                mem_cmd_addr  = {addr_q, {OFF_W{1'b0}}};
                mem_cmd_wline = {WORDS{wdata_q}};
                if (mem_cmd_ready) nxt = act_q.is_load ? S_UWAIT : S_RESP;
            end
            S_UWAIT: if (mem_rd_valid) nxt = S_RESP;
            S_RESP:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            act_q   <= '0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && req_valid) begin
                addr_q  <= req_addr[ADDR_W-1:OFF_W];
                wdata_q <= req_wdata;
                act_q   <= act_in;
                rdata_q <= '0;
            end else if (state == S_LOOK && act_q.is_load && !act_q.bypass
                         && hit && !act_q.refill) begin
                rdata_q <= st_word;
            end else if ((state == S_FWAIT || state == S_UWAIT) && mem_rd_valid) begin
                rdata_q <= mem_word;
            end
        end
    end

    assign fill_tag   = tag_c;
    assign fill_line  = mem_rd_line;
    assign word_sel   = wsel_c;
    assign word_data  = wdata_q;
    assign req_ready  = (state == S_IDLE);
    assign resp_valid = (state == S_RESP);
    assign resp_rdata = rdata_q;

endmodule

// File: rtl/hinted_dcache.sv
// Direct-mapped data cache controller driven by per-access hints and
// per-page policy. One request in flight; line-based memory port.
// Assumes the memory side answers every read command with one line.
module hinted_dcache
    import hdc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [2:0]              req_hint,
    input  logic [1:0]              req_policy,
    output logic                    resp_valid,
    output logic [DATA_W-1:0]       resp_rdata,
    output logic                    mem_cmd_valid,
    input  logic                    mem_cmd_ready,
    output logic [1:0]              mem_cmd_op,
    output logic [ADDR_W-1:0]       mem_cmd_addr,
    output logic [WORDS*DATA_W-1:0] mem_cmd_wline,
    input  logic                    mem_rd_valid,
    input  logic [WORDS*DATA_W-1:0] mem_rd_line
);

    localparam int OFF_W  = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W;
    localparam int LINE_W = WORDS * DATA_W;

    act_t              act;
    logic [IDX_W-1:0]  st_idx;
    logic              st_valid, st_dirty;
    logic [TAG_W-1:0]  st_tag, fill_tag;
    logic [LINE_W-1:0] st_line, fill_line;
    logic              fill_we, word_we, word_dirty, inval_we;
    logic [WSEL_W-1:0] word_sel;
    logic [DATA_W-1:0] word_data;

    hdc_decode u_dec (
        .hint   (req_hint),
        .policy (req_policy),
        .act    (act)
    );

    hdc_ctrl #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WORDS (WORDS), .LINES (LINES)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .act_in        (act),
        .resp_valid    (resp_valid),
        .resp_rdata    (resp_rdata),
        .mem_cmd_valid (mem_cmd_valid),
        .mem_cmd_ready (mem_cmd_ready),
        .mem_cmd_op    (mem_cmd_op),
        .mem_cmd_addr  (mem_cmd_addr),
        .mem_cmd_wline (mem_cmd_wline),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_line   (mem_rd_line),
        .st_idx        (st_idx),
        .st_valid      (st_valid),
        .st_dirty      (st_dirty),
        .st_tag        (st_tag),
        .st_line       (st_line),
        .fill_we       (fill_we),
        .fill_tag      (fill_tag),
        .fill_line     (fill_line),
        .word_we       (word_we),
        .word_sel      (word_sel),
        .word_data     (word_data),
        .word_dirty    (word_dirty),
        .inval_we      (inval_we)
    );

    hdc_store #(
        .LINES (LINES), .WORDS (WORDS), .DATA_W (DATA_W), .TAG_W (TAG_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (st_idx),
        .rd_valid   (st_valid),
        .rd_dirty   (st_dirty),
        .rd_tag     (st_tag),
        .rd_line    (st_line),
        .fill_we    (fill_we),
        .fill_tag   (fill_tag),
        .fill_line  (fill_line),
        .word_we    (word_we),
        .word_sel   (word_sel),
        .word_data  (word_data),
        .word_dirty (word_dirty),
        .inval_we   (inval_we)
    );

endmodule

// File: rtl/hdc_checker.sv
// Port-level protocol and hint checks for hinted_dcache, bound below.
// Tracks the hint and policy of the request in flight.
module hdc_checker
    import hdc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_hint,
    input logic [1:0]        req_policy,
    input logic              resp_valid,
    input logic              mem_cmd_valid,
    input logic              mem_cmd_ready,
    input logic [1:0]        mem_cmd_op,
    input logic [ADDR_W-1:0] mem_cmd_addr
);

    localparam int LOW_W = $clog2(WORDS) + $clog2(DATA_W / 8);

    logic       busy_q;
    logic [2:0] hint_q;
    logic [1:0] pol_q;
    logic       saw_rdline_q;

    // Record the request in flight and whether it read a line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            hint_q       <= '0;
            pol_q        <= '0;
            saw_rdline_q <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                busy_q       <= 1'b1;
                hint_q       <= req_hint;
                pol_q        <= req_policy;
                saw_rdline_q <= 1'b0;
            end else begin
                if (mem_cmd_valid && mem_cmd_ready && mem_cmd_op == MOP_RD_LINE)
                    saw_rdline_q <= 1'b1;
                if (resp_valid) busy_q <= 1'b0;
            end
        end
    end

    a_r11_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    a_r11_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    a_r11_cmd_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> busy_q);
    a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid && !mem_cmd_ready |=>
            mem_cmd_valid && $stable(mem_cmd_op) && $stable(mem_cmd_addr));
    a_r12_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid && !mem_cmd_op[1] |-> mem_cmd_addr[LOW_W-1:0] == '0);
    a_r8_uncached_words: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && pol_q == POL_UC && mem_cmd_valid |-> mem_cmd_op[1]);
    a_r3_conly_word_only: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && hint_q == HINT_CONLY && mem_cmd_valid |-> mem_cmd_op == MOP_WR_WORD);
    a_r7_wt_store_word: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && hint_q == HINT_STORE && pol_q == POL_WT && mem_cmd_valid
            |-> mem_cmd_op == MOP_WR_WORD);
    a_r2_refresh_reads: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && busy_q && hint_q == HINT_REFRESH && pol_q != POL_UC
            |-> saw_rdline_q);

endmodule

bind hinted_dcache hdc_checker #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WORDS (WORDS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_hint      (req_hint),
    .req_policy    (req_policy),
    .resp_valid    (resp_valid),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_cmd_ready (mem_cmd_ready),
    .mem_cmd_op    (mem_cmd_op),
    .mem_cmd_addr  (mem_cmd_addr)
);

// File: tb/sim_hinted_dcache.sv
`timescale 1ns/100ps
module sim_hinted_dcache;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [2:0]   req_hint = '0;
    logic [1:0]   req_policy = '0;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         mem_cmd_valid;
    logic         mem_cmd_ready = 1'b0;
    logic [1:0]   mem_cmd_op;
    logic [31:0]  mem_cmd_addr;
    logic [127:0] mem_cmd_wline;
    logic         mem_rd_valid = 1'b0;
    logic [127:0] mem_rd_line = '0;

    int tests = 0;
    int fails = 0;
    int op_cnt = 0;
    int misalign = 0;
    int ready_leak = 0;
    int cyc = 0;
    logic done = 1'b0;
    logic mem_init = 1'b0;
    logic poke_en = 1'b0;
    logic [7:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;
    logic [31:0] mem [256];

    always #2.5 clk = ~clk;

    hinted_dcache u0 (.*);

    // Memory model: throttled acceptance, read data one cycle after accept
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_cmd_ready <= (cyc % 3 != 1);
        mem_rd_valid  <= 1'b0;
        if (!mem_init) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + i;
            mem_init <= 1'b1;
        end else if (poke_en) begin
            mem[poke_idx] <= poke_val;
        end
        if (mem_cmd_valid && mem_cmd_ready) begin
            op_cnt <= op_cnt + 1;
            if (!mem_cmd_op[1] && mem_cmd_addr[3:0] != 4'h0) misalign <= misalign + 1;
            case (mem_cmd_op)
                2'd0, 2'd2: begin
                    mem_rd_valid <= 1'b1;
                    for (int w = 0; w < 4; w++)
                        mem_rd_line[w*32 +: 32] <= mem[{mem_cmd_addr[9:4], 2'(w)}];
                end
                2'd1: for (int w = 0; w < 4; w++)
                        mem[{mem_cmd_addr[9:4], 2'(w)}] <= mem_cmd_wline[w*32 +: 32];
                default: mem[mem_cmd_addr[9:2]] <= mem_cmd_wline[mem_cmd_addr[3:2]*32 +: 32];
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] h, input logic [1:0] p, input logic [31:0] a,
                          input logic [31:0] d, output logic [31:0] rd, output int n);
        int n0;
        @(negedge clk);
        req_valid = 1'b1; req_hint = h; req_policy = p; req_addr = a; req_wdata = d;
        n0 = op_cnt;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) begin
            if (req_ready) ready_leak++;
            @(negedge clk);
        end
        rd = resp_rdata;
        n  = op_cnt - n0;
    endtask

    typedef struct packed {
        logic [2:0]  hint;
        logic [1:0]  pol;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  cmds;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 2'd0, 32'h040, 32'h0,        32'hA000_0010, 4'd1}, // R1 miss
        '{3'd0, 2'd0, 32'h044, 32'h0,        32'hA000_0011, 4'd0}, // R1 hit
        '{3'd4, 2'd0, 32'h044, 32'h1111_1111, 32'h0,        4'd0}, // R6 store hit
        '{3'd0, 2'd0, 32'h044, 32'h0,        32'h1111_1111, 4'd0}, // R6
        '{3'd0, 2'd0, 32'h140, 32'h0,        32'hA000_0050, 4'd2}, // R6 wb+fill
        '{3'd0, 2'd0, 32'h044, 32'h0,        32'h1111_1111, 4'd1}, // R6 written back
        '{3'd5, 2'd0, 32'h048, 32'h2222_2222, 32'h0,        4'd0}, // R3 hit
        '{3'd1, 2'd0, 32'h048, 32'h0,        32'h2222_2222, 4'd2}, // R2 dirty refresh
        '{3'd6, 2'd0, 32'h04C, 32'h3333_3333, 32'h0,        4'd1}, // R4
        '{3'd0, 2'd0, 32'h04C, 32'h0,        32'h3333_3333, 4'd0}, // R4 kept
        '{3'd7, 2'd0, 32'h040, 32'h4444_4444, 32'h0,        4'd1}, // R5 clean drop
        '{3'd0, 2'd0, 32'h040, 32'h0,        32'h4444_4444, 4'd1}, // R5 dropped
        '{3'd4, 2'd1, 32'h040, 32'h5555_5555, 32'h0,        4'd1}, // R7
        '{3'd0, 2'd0, 32'h140, 32'h0,        32'hA000_0050, 4'd1}, // R7 no wb
        '{3'd5, 2'd0, 32'h200, 32'h6666_6666, 32'h0,        4'd1}, // R3 miss
        '{3'd0, 2'd0, 32'h200, 32'h0,        32'h6666_6666, 4'd1}, // R3 no alloc
        '{3'd4, 2'd2, 32'h204, 32'h7777_7777, 32'h0,        4'd1}, // R8 store
        '{3'd0, 2'd0, 32'h204, 32'h0,        32'hA000_0081, 4'd0}, // R8 array kept
        '{3'd4, 2'd3, 32'h208, 32'h8888_8888, 32'h0,        4'd0}, // R9
        '{3'd3, 2'd0, 32'h208, 32'h0,        32'h8888_8888, 4'd0}, // R10
        '{3'd2, 2'd0, 32'h208, 32'h0,        32'h8888_8888, 4'd0}, // R10
        '{3'd7, 2'd0, 32'h20C, 32'h9999_9999, 32'h0,        4'd1}, // R5 dirty drop
        '{3'd0, 2'd0, 32'h208, 32'h0,        32'h8888_8888, 4'd1}, // R5
        '{3'd0, 2'd0, 32'h20C, 32'h0,        32'h9999_9999, 4'd0}, // R5 merged
        '{3'd0, 2'd2, 32'h210, 32'h0,        32'hA000_0084, 4'd1}, // R8 load
        '{3'd0, 2'd0, 32'h210, 32'h0,        32'hA000_0084, 4'd1}  // R8 no alloc
    };

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n;
        repeat (4) @(negedge clk);
        // R13 reset state
        chk("R13 ready", {31'b0, req_ready}, 32'd1);
        chk("R13 resp", {31'b0, resp_valid}, 32'd0);
        chk("R13 cmd", {31'b0, mem_cmd_valid}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].hint, VEC[i].pol, VEC[i].addr, VEC[i].wdata, rd, n);
            if (!VEC[i].hint[2]) chk($sformatf("vec%0d rdata", i), rd, VEC[i].exp);
            chk($sformatf("vec%0d memory commands", i), n, {28'b0, VEC[i].cmds});
        end

        // R2 refresh picks up a change made behind the cache
        @(negedge clk); poke_en = 1'b1; poke_idx = 8'd132; poke_val = 32'hCAFE_0001;
        @(negedge clk); poke_en = 1'b0;
        access(3'd0, 2'd0, 32'h210, 32'h0, rd, n);
        chk("R1 stale hit", rd, 32'hA000_0084);
        chk("R1 hit cmds", n, 0);
        access(3'd1, 2'd0, 32'h210, 32'h0, rd, n);
        chk("R2 refresh data", rd, 32'hCAFE_0001);
        chk("R2 refresh cmds", n, 1);

        // R13 reset mid-run clears valid bits
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13 ready in reset", {31'b0, req_ready}, 32'd1);
        chk("R13 cmd in reset", {31'b0, mem_cmd_valid}, 32'd0);
        rst_n = 1'b1;
        access(3'd0, 2'd0, 32'h210, 32'h0, rd, n);
        chk("R13 miss after reset", n, 1);
        chk("R13 data after reset", rd, 32'hCAFE_0001);

        // R11 and R12 across the whole run
        chk("R11 ready while busy", ready_leak, 0);
        chk("R12 misaligned line cmds", misalign, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule